// File: doc/BRIEF.md
# Output pixel format converter

This block takes a stream of 32-bit ARGB pixels and turns each one into one of five output colour formats. A 3-bit mode input selects the format. Two controls adjust every pixel before it is packed: one inverts the alpha channel bitwise, and the other exchanges the red and blue channels. When a format keeps fewer bits per channel, each channel keeps its most significant bits.

Each converted pixel is 4, 3 or 2 bytes long. The pixels are packed back to back, little-endian, into 32-bit output words. A 3-byte pixel can therefore be split across two words. A word is sent only when all four of its bytes are filled. The exception is the word that closes a stream: it may be partial, and its byte enables then mark the valid low bytes. It also carries the last flag.

Both sides use a valid/ready handshake. When the output stalls, the input stalls too, and no pixel is lost or repeated. The mode and the two controls are expected to stay constant within a stream.

Top module: `pix_out_conv`

## Requirements
- R1: Mode 000 produces 4 bytes per pixel, in memory order B, G, R, A (byte 0 holds B). Modes 101 to 111 behave the same way.
- R2: Mode 001 produces 3 bytes per pixel, in order B, G, R. Consecutive pixels fill bytes back to back, so the second pixel starts at byte 3 of the first word and continues into the next word.
- R3: Mode 010 produces a 16-bit value {R[7:3], G[7:2], B[7:3]}. Its low byte is stored first.
- R4: Mode 011 produces a 16-bit value {A[7], R[7:3], G[7:3], B[7:3]}.
- R5: Mode 100 produces a 16-bit value {A[7:4], R[7:4], G[7:4], B[7:4]}.
- R6: When alpha_inv is 1, alpha is replaced by its bitwise inverse before the depth reduction is applied.
- R7: When rb_swap is 1, the input's R value is output where B would go, and B where R would go.
- R8: A word that does not end a stream has out_be = 4'b1111. The final word has out_be = 4'b0001, 4'b0011, 4'b0111 or 4'b1111, matching the 1 to 4 bytes that remain.
- R9: out_last is 1 only on the word that holds the last byte of a pixel accepted with in_last = 1.
- R10: While out_valid = 1 and out_ready = 0, out_data, out_be and out_last hold steady. Under any out_ready pattern, every byte appears exactly once and in order.
- R11: After reset, out_valid = 0 and in_ready = 1.
- R12: After a pixel with in_last = 1 has been accepted, in_ready stays 0 until the final word has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Output format select |
| alpha_inv | input | 1 | Invert alpha before conversion |
| rb_swap | input | 1 | Exchange red and blue |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Converter can take a pixel |
| in_pixel | input | 32 | ARGB pixel {A, R, G, B} |
| in_last | input | 1 | Pixel ends the stream |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 32 | Packed little-endian word |
| out_be | output | 4 | Byte enables of out_data |
| out_last | output | 1 | Word ends the stream |

## Verification
The assertions assume that the sink follows the handshake, so an offered word is not withdrawn. They also assume that mode, alpha_inv and rb_swap do not change while a stream is being packed.

The stimulus changes the mode and the controls only between streams, after the final word has drained. It drives out_ready shortly after the clock edge, using either a fixed level or a varying pattern. Input pixels are offered and held until they are accepted.

// File: rtl/pix_out_conv.sv
module pix_out_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode,
  input  logic        alpha_inv,
  input  logic        rb_swap,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_pixel,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_be,
  output logic        out_last
);

  logic [7:0]  ch_a, ch_r, ch_g, ch_b;
  logic [31:0] px_conv;
  logic [3:0]  px_len;
  logic [63:0] acc;
  logic [3:0]  cnt;
  logic        last_pend;
  logic        push, pop;
  logic [3:0]  take;
  logic [2:0]  base;

  assign ch_a = alpha_inv ? ~in_pixel[31:24] : in_pixel[31:24];
  assign ch_r = rb_swap ? in_pixel[7:0]   : in_pixel[23:16];
  assign ch_g = in_pixel[15:8];
  assign ch_b = rb_swap ? in_pixel[23:16] : in_pixel[7:0];

  always_comb begin
    case (mode)
      3'b001: begin px_conv = {8'h00, ch_r, ch_g, ch_b}; px_len = 4'd3; end
      3'b010: begin px_conv = {16'h0, ch_r[7:3], ch_g[7:2], ch_b[7:3]}; px_len = 4'd2; end
      3'b011: begin px_conv = {16'h0, ch_a[7], ch_r[7:3], ch_g[7:3], ch_b[7:3]}; px_len = 4'd2; end
      3'b100: begin px_conv = {16'h0, ch_a[7:4], ch_r[7:4], ch_g[7:4], ch_b[7:4]}; px_len = 4'd2; end
      default: begin px_conv = {ch_a, ch_r, ch_g, ch_b}; px_len = 4'd4; end
    endcase
  end

  assign in_ready  = !last_pend && (cnt <= 4'd4);
  assign out_valid = (cnt >= 4'd4) || (last_pend && cnt != 4'd0);
  assign out_last  = last_pend && (cnt <= 4'd4);
  assign out_data  = acc[31:0];
  always_comb begin
    case (cnt)
      4'd1: out_be = 4'b0001;
      4'd2: out_be = 4'b0011;
      4'd3: out_be = 4'b0111;
      default: out_be = 4'b1111;
    endcase
  end

  assign push = in_valid && in_ready;
  assign pop  = out_valid && out_ready;
  assign take = pop ? ((cnt >= 4'd4) ? 4'd4 : cnt) : 4'd0;
  assign base = 3'(cnt - take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      last_pend <= 1'b0;
    end else begin
      acc <= (pop ? {32'h0, acc[63:32]} : acc)
             | (push ? ({32'h0, px_conv} << {base, 3'b000}) : 64'h0);
      cnt <= cnt - take + (push ? px_len : 4'd0);
      if (push && in_last)
        last_pend <= 1'b1;
      else if (pop && cnt <= 4'd4)
        last_pend <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be) && $stable(out_last));
  assert_full_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_be == 4'b1111);
  assert_tail_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_be inside {4'b0001, 4'b0011, 4'b0111, 4'b1111});
  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_block_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_last && !out_ready |=> !in_ready);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);

endmodule

// File: tb/test_pix_out_conv.sv
module test_pix_out_conv;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] mode = 0;
  logic alpha_inv = 0, rb_swap = 0;
  logic in_valid = 0, in_last = 0;
  logic [31:0] in_pixel = 0;
  logic in_ready, out_valid, out_last;
  logic out_ready = 1;
  logic [31:0] out_data;
  logic [3:0] out_be;

  int checks = 0, errors = 0;
  int n_out = 0;
  logic [31:0] got_d [0:63];
  logic [3:0]  got_b [0:63];
  logic        got_l [0:63];
  logic bp = 0, hold = 0;
  logic [2:0] tick = 0;

  always #2.5 clk = ~clk;

  pix_out_conv i_pix_out_conv (.clk, .rst_n, .mode, .alpha_inv, .rb_swap,
    .in_valid, .in_ready, .in_pixel, .in_last,
    .out_valid, .out_ready, .out_data, .out_be, .out_last);

  always @(posedge clk) begin
    #1;
    tick = tick + 1;
    out_ready = hold ? 1'b0 : (bp ? (tick[0] ^ tick[2]) : 1'b1);
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && n_out < 64) begin
      got_d[n_out] = out_data;
      got_b[n_out] = out_be;
      got_l[n_out] = out_last;
      n_out = n_out + 1;
    end
  end

  // {mode, alpha_inv, rb_swap, pixel, data, be}
  localparam logic [72:0] VEC [0:11] = '{
    {3'd0, 1'b0, 1'b0, 32'h80C35AF1, 32'h80C35AF1, 4'hF},
    {3'd0, 1'b1, 1'b0, 32'h80C35AF1, 32'h7FC35AF1, 4'hF},
    {3'd0, 1'b0, 1'b1, 32'h80C35AF1, 32'h80F15AC3, 4'hF},
    {3'd1, 1'b0, 1'b0, 32'h80C35AF1, 32'h00C35AF1, 4'h7},
    {3'd1, 1'b0, 1'b1, 32'h80C35AF1, 32'h00F15AC3, 4'h7},
    {3'd2, 1'b0, 1'b0, 32'h80C35AF1, 32'h0000C2DE, 4'h3},
    {3'd2, 1'b0, 1'b1, 32'h80C35AF1, 32'h0000F2D8, 4'h3},
    {3'd3, 1'b0, 1'b0, 32'h80C35AF1, 32'h0000E17E, 4'h3},
    {3'd3, 1'b1, 1'b0, 32'h80C35AF1, 32'h0000617E, 4'h3},
    {3'd4, 1'b0, 1'b0, 32'h80C35AF1, 32'h00008C5F, 4'h3},
    {3'd4, 1'b1, 1'b0, 32'h80C35AF1, 32'h00007C5F, 4'h3},
    {3'd4, 1'b0, 1'b1, 32'h80C35AF1, 32'h00008F5C, 4'h3}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] pix, input logic last);
    in_pixel = pix; in_last = last; in_valid = 1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_words(input int n);
    int guard = 0;
    while (n_out < n && guard < 200) begin @(negedge clk); guard++; end
    #1;
  endtask

  task automatic check_word(input string req, input int idx, input logic [31:0] d,
                            input logic [3:0] be, input logic last);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    check(req, {got_d[idx] & m, got_b[idx]}, {d & m, be});
    check({req, " last"}, {35'd0, got_l[idx]}, {35'd0, last});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R11 reset", {34'd0, out_valid, in_ready}, {34'd0, 1'b0, 1'b1});

    // R1 R3 R4 R5 R6 R7: single-pixel streams from the table
    for (int k = 0; k < 12; k++) begin
      base = n_out;
      mode = VEC[k][72:70]; alpha_inv = VEC[k][69]; rb_swap = VEC[k][68];
      send(VEC[k][67:36], 1'b1);
      wait_words(base + 1);
      check_word($sformatf("R1-vector%0d", k), base, VEC[k][35:4], VEC[k][3:0], 1'b1);
    end
    alpha_inv = 0; rb_swap = 0;

    // R2 R10: RGB888 straddling words under back-pressure
    bp = 1; mode = 3'd1; base = n_out;
    send(32'h11223344, 0); send(32'h55667788, 0);
    send(32'h99AABBCC, 0); send(32'hDDEEFF01, 1);
    wait_words(base + 3);
    check_word("R2 w0", base,     32'h88223344, 4'hF, 0);
    check_word("R10 w1", base + 1, 32'hBBCC6677, 4'hF, 0);
    check_word("R9 w2", base + 2, 32'hEEFF01AA, 4'hF, 1);
    check("R10 count", 36'(n_out - base), 36'd3);

    // R8: RGB565 three pixels, partial tail
    mode = 3'd2; base = n_out;
    send(32'h00FF0000, 0); send(32'h0000FF00, 0); send(32'h000000FF, 1);
    wait_words(base + 2);
    check_word("R3 w0", base,     32'h07E0F800, 4'hF, 0);
    check_word("R8 tail", base + 1, 32'h0000001F, 4'h3, 1);
    bp = 0;

    // R2 R8: RGB888 two pixels, tail of two bytes
    mode = 3'd1; base = n_out;
    send(32'h00010203, 0); send(32'h00040506, 1);
    wait_words(base + 2);
    check_word("R2 w0", base,     32'h06010203, 4'hF, 0);
    check_word("R8 tail2", base + 1, 32'h00000405, 4'h3, 1);

    // R12 R10: stalled final word blocks input and holds steady
    @(posedge clk); #1 hold = 1;
    @(negedge clk);
    mode = 3'd4; base = n_out;
    send(32'h80C35AF1, 1);
    #1;
    check("R12 blocked", {33'd0, in_ready, out_valid, out_last}, {33'd0, 1'b0, 1'b1, 1'b1});
    repeat (3) @(negedge clk);
    #1;
    check("R10 hold", {out_data, out_be}, {32'h00008C5F, 4'h3});
    check("R12 still", {35'd0, in_ready}, 36'd0);
    @(posedge clk); #2 hold = 0;
    wait_words(base + 1);
    check_word("R5 stalled", base, 32'h00008C5F, 4'h3, 1);
    @(negedge clk); #1;
    check("R12 released", {34'd0, in_ready, out_valid}, {34'd0, 1'b1, 1'b0});

    finish_run();
  end
endmodule